// File: doc/BRIEF.md
# Shared Timer Prescaler with Event Counter

This block produces one programmable clock-enable pulse, the tick, for a group of timer/counters and a watchdog. A 4-bit divide code sets the tick period anywhere from every system clock to every sixteenth clock. The code that reset loads depends on the operating mode. Compatibility mode loads a code that gives one tick per machine cycle. Fast mode loads zero, so the tick is present on every clock.

The same tick sets how often the external count and interrupt pins are sampled. In compatibility mode a pin is captured only on a tick. In fast mode pins are captured on every clock.

One up-counter is built into the block. In timer mode it advances on ticks. In counter mode it advances on falling edges of a chosen pin. A bypass input lets special timer modes count on the undivided clock instead. When the counter wraps it sets a sticky overflow flag and, if enabled, inverts an output pin.

Top module: `tmr_prescale_unit`

## Requirements
- R1: Reset loads divide code 5 when `fast_mode` is 0 and code 0 when it is 1. The internal count starts at zero, with the first cycle that has reset low counted as cycle one. After reset in compatibility mode, `tick` is first high in cycle six and then once every six cycles. In fast mode it is high in every cycle.
- R2: With divide code c held, `tick` is a one-cycle pulse that repeats every c+1 clocks. For c = 0 it stays high.
- R3: A write (`div_wr` high for one cycle with code c on `div_code`) restarts the internal count. The first tick after the write arrives c+1 cycles after the write cycle.
- R4: With `fast_mode` 0, `pins_smp` captures `ext_pins` only at the clock edge that ends a tick cycle. Pin changes between ticks, including short pulses, do not appear on `pins_smp`.
- R5: With `fast_mode` 1, `pins_smp` follows `ext_pins` with one cycle of latency on every clock.
- R6: In timer mode (`cnt_sel` 0, `bypass` 0), `count` advances by exactly one for each tick.
- R7: In timer mode with `bypass` 1, `count` advances on every clock, whatever the divide code and mode are.
- R8: In counter mode (`cnt_sel` 1), `count` advances once for each pair of consecutive samples of pin 0 that reads 1 and then 0. A low pulse that falls between two compatibility-mode samples is not counted.
- R9: The wrap from all ones to zero sets `ovf_flag`. The flag stays set until `ovf_clr` is high for a cycle. If a wrap and `ovf_clr` arrive in the same cycle, the flag is set.
- R10: With `tgl_en` 1, every wrap inverts `tgl_pin`. With `tgl_en` 0, a wrap leaves `tgl_pin` unchanged. `tgl_pin` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_mode | input | 1 | 0 = compatibility mode, 1 = fast mode |
| div_wr | input | 1 | Load strobe for the divide code |
| div_code | input | DIV_W | New divide code |
| bypass | input | 1 | Timer counts on the undivided clock |
| cnt_sel | input | 1 | 0 = timer mode, 1 = counter mode on pin CNT_PIN |
| tgl_en | input | 1 | Enables pin inversion on a wrap |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_pins | input | NPINS | External count and interrupt pins |
| tick | output | 1 | Prescaled clock-enable pulse |
| pins_smp | output | NPINS | Sampled pin values |
| count | output | CNT_W | Up-counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| tgl_pin | output | 1 | Pin inverted on each overflow |

## Verification
The hardest state to reach from the ports is the counter wrap, because it needs the full range of increments. The bench builds the block with a narrower counter width and drives `bypass` so the counter steps on every clock. This brings it to all ones quickly and repeatedly, with toggle enabled on some wraps and disabled on others.

The other delicate case is a pin pulse that falls between two compatibility-mode samples. To create it, the bench waits for an observed tick and then lowers the pin for exactly one cycle inside the gap.

// File: rtl/tps_pkg.sv
package tps_pkg;
   typedef enum logic {
      MODE_COMPAT = 1'b0,
      MODE_FAST   = 1'b1
   } tps_mode_e;
endpackage

// File: rtl/tps_divider.sv
module tps_divider
   import tps_pkg::*;
#(
   parameter int DIV_W       = 4,
   parameter int COMPAT_CODE = 5,
   parameter int FAST_CODE   = 0
)(
   input  logic             clk,
   input  logic             rst,
   input  tps_mode_e        mode,
   input  logic             wr,
   input  logic [DIV_W-1:0] code_in,
   output logic             tick
);
   localparam logic [DIV_W-1:0] CODE_COMPAT = DIV_W'(COMPAT_CODE);
   localparam logic [DIV_W-1:0] CODE_FAST   = DIV_W'(FAST_CODE);

   logic [DIV_W-1:0] code_q;
   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q == code_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= (mode == MODE_FAST) ? CODE_FAST : CODE_COMPAT;
         cnt_q  <= '0;
      end else if (wr) begin
         code_q <= code_in;
         cnt_q  <= '0;
      end else if (tick) begin
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   AST_FAST_RESET_TICK: assert property (@(posedge clk) disable iff (rst)
      ($fell(rst) && mode == MODE_FAST) |-> tick); // R1
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (tick && code_q != '0 && !wr) |=> !tick); // R2
   AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
      (wr && code_in != '0) |=> !tick); // R3
endmodule

// File: rtl/tps_sampler.sv
module tps_sampler
   import tps_pkg::*;
#(
   parameter int NPINS   = 4,
   parameter int CNT_PIN = 0
)(
   input  logic             clk,
   input  logic             rst,
   input  tps_mode_e        mode,
   input  logic             tick,
   input  logic [NPINS-1:0] pins,
   output logic [NPINS-1:0] smp,
   output logic             fall
);
   logic samp_en;
   logic fall_q;

   assign samp_en = (mode == MODE_FAST) || tick;

   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      logic bit_q;
      always_ff @(posedge clk) begin
         if (rst)          bit_q <= 1'b0;
         else if (samp_en) bit_q <= pins[g];
      end
      assign smp[g] = bit_q;
   end

   always_ff @(posedge clk) begin
      if (rst)          fall_q <= 1'b0;
      else if (samp_en) fall_q <= smp[CNT_PIN] & ~pins[CNT_PIN];
      else              fall_q <= 1'b0;
   end
   assign fall = fall_q;

   AST_COMPAT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_COMPAT && !tick) |=> $stable(smp)); // R4
   AST_FAST_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_FAST) |=> (smp == $past(pins))); // R5
   AST_FALL_ONLY_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
      (!samp_en) |=> !fall); // R8
endmodule

// File: rtl/tps_counter.sv
module tps_counter #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             bypass,
   input  logic             cnt_sel,
   input  logic             fall,
   input  logic             tgl_en,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf,
   output logic             tgl
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             tgl_q;
   logic             inc;
   logic             wrap;

   always_comb begin
      if (cnt_sel)     inc = fall;
      else if (bypass) inc = 1'b1;
      else             inc = tick;
   end

   assign wrap = inc && (cnt_q == CNT_TOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         tgl_q <= 1'b0;
      end else begin
         if (inc)               cnt_q <= cnt_q + 1'b1;
         if (wrap)              ovf_q <= 1'b1;
         else if (ovf_clr)      ovf_q <= 1'b0;
         if (wrap && tgl_en)    tgl_q <= ~tgl_q;
      end
   end

   assign count = cnt_q;
   assign ovf   = ovf_q;
   assign tgl   = tgl_q;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!inc) |=> $stable(cnt_q)); // R6
   AST_BYPASS_STEP: assert property (@(posedge clk) disable iff (rst)
      (bypass && !cnt_sel) |=> (cnt_q != $past(cnt_q))); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      (ovf_q && !ovf_clr) |=> ovf_q); // R9
   AST_TOGGLE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
      (inc && cnt_q == CNT_TOP && tgl_en) |=> (tgl_q != $past(tgl_q))); // R10
endmodule

// File: rtl/tmr_prescale_unit.sv
module tmr_prescale_unit
   import tps_pkg::*;
#(
   parameter int DIV_W       = 4,
   parameter int COMPAT_CODE = 5,
   parameter int FAST_CODE   = 0,
   parameter int NPINS       = 4,
   parameter int CNT_PIN     = 0,
   parameter int CNT_W       = 16
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             fast_mode,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_code,
   input  logic             bypass,
   input  logic             cnt_sel,
   input  logic             tgl_en,
   input  logic             ovf_clr,
   input  logic [NPINS-1:0] ext_pins,
   output logic             tick,
   output logic [NPINS-1:0] pins_smp,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             tgl_pin
);
   localparam int CODE_LIMIT = 1 << DIV_W;

   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div_w
      $error("DIV_W must lie in 1..8");
   end
   if (COMPAT_CODE < 0 || COMPAT_CODE >= CODE_LIMIT || FAST_CODE < 0 || FAST_CODE >= CODE_LIMIT) begin : g_bad_code
      $error("reset codes must fit in DIV_W bits");
   end
   if (CNT_PIN < 0 || CNT_PIN >= NPINS) begin : g_bad_pin
      $error("CNT_PIN must index ext_pins");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end

   tps_mode_e mode;
   logic      fall;

   assign mode = tps_mode_e'(fast_mode);

   tps_divider #(
      .DIV_W       (DIV_W),
      .COMPAT_CODE (COMPAT_CODE),
      .FAST_CODE   (FAST_CODE)
   ) u_div (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode),
      .wr      (div_wr),
      .code_in (div_code),
      .tick    (tick)
   );

   tps_sampler #(
      .NPINS   (NPINS),
      .CNT_PIN (CNT_PIN)
   ) u_smp (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .tick (tick),
      .pins (ext_pins),
      .smp  (pins_smp),
      .fall (fall)
   );

   tps_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .bypass  (bypass),
      .cnt_sel (cnt_sel),
      .fall    (fall),
      .tgl_en  (tgl_en),
      .ovf_clr (ovf_clr),
      .count   (count),
      .ovf     (ovf_flag),
      .tgl     (tgl_pin)
   );
endmodule

// File: tb/tmr_prescale_unit_tb_top.sv
module tmr_prescale_unit_tb_top;
   localparam int CLK_PER = 10;
   localparam int TB_CW   = 12;
   localparam int NP      = 4;
   localparam logic [TB_CW-1:0] TOP = '1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fast_mode = 1'b0;
   logic div_wr = 1'b0;
   logic [3:0] div_code = '0;
   logic bypass = 1'b0;
   logic cnt_sel = 1'b0;
   logic tgl_en = 1'b0;
   logic ovf_clr = 1'b0;
   logic [NP-1:0] ext_pins = '0;
   logic tick;
   logic [NP-1:0] pins_smp;
   logic [TB_CW-1:0] count;
   logic ovf_flag;
   logic tgl_pin;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PER/2) clk = ~clk;

   tmr_prescale_unit #(.NPINS(NP), .CNT_W(TB_CW)) dut_i (
      .clk(clk), .rst(rst), .fast_mode(fast_mode), .div_wr(div_wr), .div_code(div_code),
      .bypass(bypass), .cnt_sel(cnt_sel), .tgl_en(tgl_en), .ovf_clr(ovf_clr),
      .ext_pins(ext_pins), .tick(tick), .pins_smp(pins_smp), .count(count),
      .ovf_flag(ovf_flag), .tgl_pin(tgl_pin)
   );

   function automatic int exp_period(input int code);
      return code + 1;
   endfunction

   function automatic logic [TB_CW-1:0] exp_count(input logic [TB_CW-1:0] base, input int steps);
      return TB_CW'(int'(base) + steps);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic fm);
      fast_mode = fm;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic load_code(input int c);
      div_code = 4'(c);
      div_wr = 1'b1;
      @(negedge clk);
      div_wr = 1'b0;
   endtask

   task automatic first_tick(output int k);
      k = 1;
      while (!tick && k < 40) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic next_gap(output int k);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!tick && k < 40);
   endtask

   task automatic period_check(input int c, input string tag);
      int k;
      load_code(c);
      first_tick(k);
      chk(k == exp_period(c), {tag, " R3 first tick after write"}, k, exp_period(c));
      next_gap(k);
      chk(k == exp_period(c), {tag, " R2 tick period"}, k, exp_period(c));
   endtask

   initial begin
      #(CLK_PER * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int k;
      int n;
      logic [TB_CW-1:0] c0;
      logic [NP-1:0] old_v;
      logic [NP-1:0] new_v;
      logic prev;
      logic b;
      int nf;
      void'($urandom(32'h5EED_0017));

      // R1: compatibility reset
      do_reset(1'b0);
      chk(count == '0, "R1 reset count", int'(count), 0);
      chk(ovf_flag == 1'b0, "R9 reset flag", int'(ovf_flag), 0);
      chk(tgl_pin == 1'b0, "R10 reset toggle", int'(tgl_pin), 0);
      chk(pins_smp == '0, "R1 reset samples", int'(pins_smp), 0);
      next_gap(k);
      chk(k == 5, "R1 compat first tick", k, 5);
      next_gap(k);
      chk(k == 6, "R1 compat default period", k, 6);

      for (int c = 0; c < 16; c++) period_check(c, "compat");

      // R1: fast reset
      do_reset(1'b1);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(tick == 1'b1, "R1 fast tick every cycle", int'(tick), 1);
      end
      for (int c = 15; c >= 0; c--) period_check(c, "fast");

      // R2/R3: random codes and modes
      for (int i = 0; i < 20; i++) begin
         fast_mode = 1'($urandom % 2);
         period_check(int'($urandom % 16), "random");
      end

      // R5: fast sampling
      fast_mode = 1'b1;
      for (int i = 0; i < 10; i++) begin
         new_v = NP'($urandom);
         ext_pins = new_v;
         @(negedge clk);
         chk(pins_smp == new_v, "R5 fast sample", int'(pins_smp), int'(new_v));
      end

      // R4: compatibility sampling only on ticks
      fast_mode = 1'b0;
      load_code(7);
      repeat (20) @(negedge clk);
      while (!tick) @(negedge clk);
      @(negedge clk);
      old_v = pins_smp;
      new_v = ~old_v;
      ext_pins = new_v;
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         chk(pins_smp == old_v, "R4 hold between ticks", int'(pins_smp), int'(old_v));
      end
      @(negedge clk);
      chk(pins_smp == new_v, "R4 capture after tick", int'(pins_smp), int'(new_v));

      // R6: timer counts ticks
      cnt_sel = 1'b0;
      bypass = 1'b0;
      load_code(3);
      c0 = count;
      n = 0;
      repeat (60) begin
         if (tick) n++;
         @(negedge clk);
      end
      chk(n == 15, "R2 ticks in 60 cycles at code 3", n, 15);
      chk(count == exp_count(c0, n), "R6 timer advance", int'(count), int'(exp_count(c0, n)));

      // R7: bypass counts every clock
      load_code(9);
      bypass = 1'b1;
      c0 = count;
      repeat (50) @(negedge clk);
      chk(count == exp_count(c0, 50), "R7 bypass advance", int'(count), int'(exp_count(c0, 50)));
      bypass = 1'b0;

      // R8: random falling edges in fast mode
      fast_mode = 1'b1;
      cnt_sel = 1'b1;
      ext_pins[0] = 1'b1;
      repeat (4) @(negedge clk);
      c0 = count;
      prev = 1'b1;
      nf = 0;
      for (int i = 0; i < 200; i++) begin
         b = 1'($urandom % 2);
         if (prev && !b) nf++;
         ext_pins[0] = b;
         prev = b;
         @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(count == exp_count(c0, nf), "R8 fast edge count", int'(count), int'(exp_count(c0, nf)));

      // R8: short pulse between compatibility samples is missed
      fast_mode = 1'b0;
      ext_pins[0] = 1'b1;
      load_code(7);
      repeat (20) @(negedge clk);
      c0 = count;
      while (!tick) @(negedge clk);
      @(negedge clk);
      ext_pins[0] = 1'b0;
      @(negedge clk);
      ext_pins[0] = 1'b1;
      repeat (30) @(negedge clk);
      chk(count == c0, "R8 glitch ignored", int'(count), int'(c0));
      ext_pins[0] = 1'b0;
      repeat (20) @(negedge clk);
      chk(count == exp_count(c0, 1), "R8 held low counted once", int'(count), int'(exp_count(c0, 1)));

      // R9/R10: wraps
      cnt_sel = 1'b0;
      bypass = 1'b1;
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      for (int w = 0; w < 4; w++) begin
         logic t;
         int guard;
         tgl_en = (w < 3);
         guard = 0;
         while (count != TOP && guard < 6000) begin
            @(negedge clk);
            guard++;
         end
         t = tgl_pin;
         chk(ovf_flag == 1'b0, "R9 flag clear before wrap", int'(ovf_flag), 0);
         @(negedge clk);
         chk(count == '0, "R9 wrap to zero", int'(count), 0);
         chk(ovf_flag == 1'b1, "R9 flag set on wrap", int'(ovf_flag), 1);
         if (w < 3)
            chk(tgl_pin == ~t, "R10 toggle on wrap", int'(tgl_pin), int'(~t));
         else
            chk(tgl_pin == t, "R10 no toggle when disabled", int'(tgl_pin), int'(t));
         repeat (3) @(negedge clk);
         chk(ovf_flag == 1'b1, "R9 flag sticky", int'(ovf_flag), 1);
         ovf_clr = 1'b1;
         @(negedge clk);
         ovf_clr = 1'b0;
         chk(ovf_flag == 1'b0, "R9 flag cleared", int'(ovf_flag), 0);
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule